// File: doc/BRIEF.md
# Shift, Rotate and Bit-Transfer Unit

This unit performs the single-byte shift, rotate, nibble-exchange and bit-transfer operations of a small processor datapath. Each cycle it takes an operand, a 3-bit operation code, a bit index, the current carry flag and the current transfer flag (T). One clock edge later it presents the result byte and the new zero, carry, negative, overflow and T values. Each of these values comes with its own write enable, so the surrounding core knows exactly which state to update.

Rotates pass through the carry flag, so the bit that enters comes from the incoming carry and the bit that leaves becomes the new carry. Nibble exchange and bit load write the result byte but leave every flag alone. Bit store copies one operand bit into T and leaves the result byte unwritten. An issue strobe marks cycles with no operation. The register file, the remaining status flags and the arithmetic ALU lie outside this block.

Top module: `shbit_unit`

## Requirements
- R1: Opcode 0 (shift left) gives result = operand shifted up one place with 0 entering bit 0, and new carry = old operand bit 7.
- R2: Opcode 1 (shift right) gives result = operand shifted down one place with 0 entering bit 7, and new carry = old operand bit 0.
- R3: Opcode 2 (rotate left via carry) gives result bit 0 = incoming carry and bits 7..1 = old bits 6..0, and new carry = old bit 7.
- R4: Opcode 3 (rotate right via carry) gives result bit 7 = incoming carry and bits 6..0 = old bits 7..1, and new carry = old bit 0.
- R5: Opcode 4 (arithmetic shift right) keeps bit 7, moves bits 7..1 into 6..0, and sets new carry = old bit 0.
- R6: For opcodes 0 to 4, all four flag enables and the result enable are high and the T enable is low. N = result bit 7, Z = 1 exactly when the result is zero, and V = N xor C.
- R7: Opcode 5 (nibble exchange) swaps bits 7..4 with bits 3..0, raises the result enable, and raises no flag or T enable.
- R8: Opcode 6 (bit store) sets T out to operand bit [bit index], raises the T enable, and raises neither the result enable nor any flag enable.
- R9: Opcode 7 (bit load) returns the operand with bit [bit index] replaced by incoming T, raises the result enable, and raises no flag or T enable.
- R10: Outputs are registered. Inputs sampled at a rising edge appear on the outputs after that edge, and a new operation can be issued on every cycle.
- R11: A cycle with the issue strobe low produces all enables low and all value outputs 0 after the next edge. Any value output whose enable is low reads 0.
- R12: While reset is asserted (active low, asynchronous), every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue strobe: an operation is present this cycle |
| op_i | input | 3 | Operation code (0..7, see R1 to R9) |
| operand_i | input | 8 | Operand byte |
| bit_sel_i | input | 3 | Bit index for bit store and bit load |
| c_i | input | 1 | Current carry flag |
| t_i | input | 1 | Current transfer flag |
| result_o | output | 8 | Result byte |
| result_we_o | output | 1 | Result write enable |
| z_o | output | 1 | New zero flag |
| z_we_o | output | 1 | Zero flag write enable |
| c_o | output | 1 | New carry flag |
| c_we_o | output | 1 | Carry flag write enable |
| n_o | output | 1 | New negative flag |
| n_we_o | output | 1 | Negative flag write enable |
| v_o | output | 1 | New overflow flag |
| v_we_o | output | 1 | Overflow flag write enable |
| t_o | output | 1 | New transfer flag |
| t_we_o | output | 1 | Transfer flag write enable |

## Verification
Every output of an operation is due exactly one rising edge after the edge that samples its inputs, and all outputs of that operation arrive together. The bench drives inputs on the falling edge and queues the model's expectation for each issued cycle. At the next falling edge, after the capturing edge has passed, it pops that expectation and compares it with the outputs. Back-to-back operations and idle cycles therefore check both the latency and that no operation's result leaks into the cycle that follows it.

// File: rtl/shbit_pkg.sv
`timescale 1ns/1ps
package shbit_pkg;

  typedef enum logic [2:0] {
    OP_SHL  = 3'd0,
    OP_SHR  = 3'd1,
    OP_RCL  = 3'd2,
    OP_RCR  = 3'd3,
    OP_SAR  = 3'd4,
    OP_XNIB = 3'd5,
    OP_TPUT = 3'd6,
    OP_TGET = 3'd7
  } shbit_op_e;

  typedef struct packed {
    logic z;
    logic c;
    logic n;
    logic v;
  } shbit_flags_t;

  typedef struct packed {
    logic z_we;
    logic c_we;
    logic n_we;
    logic v_we;
  } shbit_flag_we_t;

endpackage

// File: rtl/shbit_shift.sv
`timescale 1ns/1ps
module shbit_shift
  import shbit_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  shbit_op_e        op,
  input  logic [WIDTH-1:0] a,
  input  logic             c_in,
  output logic [WIDTH-1:0] res,
  output logic             shout,
  output logic             is_shift
);
  localparam int MSB = WIDTH - 1;

  function automatic logic [WIDTH-1:0] move_up(input logic [WIDTH-1:0] v, input logic fill);
    return {v[MSB-1:0], fill};
  endfunction

  function automatic logic [WIDTH-1:0] move_down(input logic [WIDTH-1:0] v, input logic fill);
    return {fill, v[MSB:1]};
  endfunction

  logic go_left;
  logic fill_bit;

  always_comb begin
    go_left  = 1'b0;
    fill_bit = 1'b0;
    is_shift = 1'b1;
    unique case (op)
      OP_SHL:  begin go_left = 1'b1; fill_bit = 1'b0;   end
      OP_RCL:  begin go_left = 1'b1; fill_bit = c_in;   end
      OP_SHR:  begin go_left = 1'b0; fill_bit = 1'b0;   end
      OP_RCR:  begin go_left = 1'b0; fill_bit = c_in;   end
      OP_SAR:  begin go_left = 1'b0; fill_bit = a[MSB]; end
      default: is_shift = 1'b0;
    endcase
  end

  assign res   = go_left ? move_up(a, fill_bit) : move_down(a, fill_bit);
  assign shout = go_left ? a[MSB] : a[0];

endmodule

// File: rtl/shbit_bitxfer.sv
`timescale 1ns/1ps
module shbit_bitxfer
  import shbit_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SELW  = $clog2(WIDTH)
) (
  input  shbit_op_e        op,
  input  logic [WIDTH-1:0] a,
  input  logic [SELW-1:0]  sel,
  input  logic             t_in,
  output logic [WIDTH-1:0] res,
  output logic             res_wr,
  output logic             t_out,
  output logic             t_wr
);
  localparam int HALF = WIDTH / 2;

  function automatic logic [WIDTH-1:0] exchange_halves(input logic [WIDTH-1:0] v);
    return {v[HALF-1:0], v[WIDTH-1:HALF]};
  endfunction

  logic [WIDTH-1:0] loaded;

  for (genvar i = 0; i < WIDTH; i++) begin : g_load
    assign loaded[i] = (sel == SELW'(i)) ? t_in : a[i];
  end

  always_comb begin
    res    = '0;
    res_wr = 1'b0;
    t_out  = 1'b0;
    t_wr   = 1'b0;
    unique case (op)
      OP_XNIB: begin res = exchange_halves(a); res_wr = 1'b1; end
      OP_TGET: begin res = loaded;             res_wr = 1'b1; end
      OP_TPUT: begin t_out = a[sel];           t_wr   = 1'b1; end
      default: ;
    endcase
  end

endmodule

// File: rtl/shbit_flags.sv
`timescale 1ns/1ps
module shbit_flags
  import shbit_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] res,
  input  logic             shout,
  input  logic             upd,
  output shbit_flags_t     flags,
  output shbit_flag_we_t   flag_we
);
  function automatic logic all_clear(input logic [WIDTH-1:0] v);
    return ~|v;
  endfunction

  logic neg;

  assign neg       = res[WIDTH-1];
  assign flags.z   = upd & all_clear(res);
  assign flags.c   = upd & shout;
  assign flags.n   = upd & neg;
  assign flags.v   = upd & (neg ^ shout);
  assign flag_we   = {4{upd}};

endmodule

// File: rtl/shbit_unit.sv
`timescale 1ns/1ps
module shbit_unit
  import shbit_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SELW  = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] operand_i,
  input  logic [SELW-1:0]  bit_sel_i,
  input  logic             c_i,
  input  logic             t_i,
  output logic [WIDTH-1:0] result_o,
  output logic             result_we_o,
  output logic             z_o,
  output logic             z_we_o,
  output logic             c_o,
  output logic             c_we_o,
  output logic             n_o,
  output logic             n_we_o,
  output logic             v_o,
  output logic             v_we_o,
  output logic             t_o,
  output logic             t_we_o
);
  localparam int MSB  = WIDTH - 1;
  localparam int HALF = WIDTH / 2;

  shbit_op_e op;
  assign op = shbit_op_e'(op_i);

  // Named internal events for the checks below
  logic [WIDTH-1:0] shift_res;
  logic             shift_out_bit;
  logic             shift_sel;
  logic             shift_issue;
  logic [WIDTH-1:0] xfer_res;
  logic             xfer_res_wr;
  logic             xfer_t;
  logic             xfer_t_wr;
  shbit_flags_t     flags_nx;
  shbit_flag_we_t   flag_we_nx;

  shbit_shift #(.WIDTH(WIDTH)) u_shift (
    .op       (op),
    .a        (operand_i),
    .c_in     (c_i),
    .res      (shift_res),
    .shout    (shift_out_bit),
    .is_shift (shift_sel)
  );

  shbit_bitxfer #(.WIDTH(WIDTH), .SELW(SELW)) u_xfer (
    .op     (op),
    .a      (operand_i),
    .sel    (bit_sel_i),
    .t_in   (t_i),
    .res    (xfer_res),
    .res_wr (xfer_res_wr),
    .t_out  (xfer_t),
    .t_wr   (xfer_t_wr)
  );

  assign shift_issue = valid_i & shift_sel;

  shbit_flags #(.WIDTH(WIDTH)) u_flags (
    .res     (shift_res),
    .shout   (shift_out_bit),
    .upd     (shift_issue),
    .flags   (flags_nx),
    .flag_we (flag_we_nx)
  );

  logic [WIDTH-1:0] res_nx;
  logic             res_we_nx;
  logic             t_nx;
  logic             t_we_nx;

  always_comb begin
    res_we_nx = valid_i & (shift_sel | xfer_res_wr);
    res_nx    = '0;
    if (shift_issue)                   res_nx = shift_res;
    else if (valid_i && xfer_res_wr)   res_nx = xfer_res;
    t_we_nx   = valid_i & xfer_t_wr;
    t_nx      = t_we_nx & xfer_t;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o    <= '0;
      result_we_o <= 1'b0;
      z_o <= 1'b0; z_we_o <= 1'b0;
      c_o <= 1'b0; c_we_o <= 1'b0;
      n_o <= 1'b0; n_we_o <= 1'b0;
      v_o <= 1'b0; v_we_o <= 1'b0;
      t_o <= 1'b0; t_we_o <= 1'b0;
    end else begin
      result_o    <= res_nx;
      result_we_o <= res_we_nx;
      z_o <= flags_nx.z; z_we_o <= flag_we_nx.z_we;
      c_o <= flags_nx.c; c_we_o <= flag_we_nx.c_we;
      n_o <= flags_nx.n; n_we_o <= flag_we_nx.n_we;
      v_o <= flags_nx.v; v_we_o <= flag_we_nx.v_we;
      t_o <= t_nx;       t_we_o <= t_we_nx;
    end
  end

  // ---------------- assertions ----------------
  a_r6_n_tracks_msb: assert property (@(posedge clk) disable iff (!rst_n)
    n_we_o |-> (n_o == result_o[MSB]));

  a_r6_z_tracks_zero: assert property (@(posedge clk) disable iff (!rst_n)
    z_we_o |-> (z_o == (result_o == '0)));

  a_r6_v_is_n_xor_c: assert property (@(posedge clk) disable iff (!rst_n)
    (v_we_o && c_we_o && n_we_o) |-> (v_o == (n_o ^ c_o)));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !(result_we_o | z_we_o | c_we_o | n_we_o | v_we_o | t_we_o)
                 && (result_o == '0));

  a_r3_rcl_carry_path: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 3'd2) |=> (result_o[0] == $past(c_i))
                                  && (c_o == $past(operand_i[MSB])));

  a_r4_rcr_carry_path: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 3'd3) |=> (result_o[MSB] == $past(c_i))
                                  && (c_o == $past(operand_i[0])));

  a_r7_xnib_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 3'd5) |=> result_we_o
      && !(z_we_o | c_we_o | n_we_o | v_we_o | t_we_o)
      && (result_o == {$past(operand_i[HALF-1:0]), $past(operand_i[MSB:HALF])}));

  a_r8_tput_only_t: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 3'd6) |=> t_we_o && !result_we_o && !z_we_o
      && (t_o == $past(operand_i[bit_sel_i])));

  a_r9_tget_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 3'd7) |=> result_we_o && !(c_we_o | t_we_o)
      && (result_o[$past(bit_sel_i)] == $past(t_i)));

endmodule

// File: tb/tb_shbit_unit.sv
`timescale 1ns/1ps
module tb_shbit_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [7:0] operand_i = '0;
  logic [2:0] bit_sel_i = '0;
  logic       c_i = 1'b0;
  logic       t_i = 1'b0;
  logic [7:0] result_o;
  logic       result_we_o, z_o, z_we_o, c_o, c_we_o, n_o, n_we_o, v_o, v_we_o, t_o, t_we_o;

  always #5 clk = ~clk;

  shbit_unit dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .operand_i(operand_i),
    .bit_sel_i(bit_sel_i), .c_i(c_i), .t_i(t_i), .result_o(result_o),
    .result_we_o(result_we_o), .z_o(z_o), .z_we_o(z_we_o), .c_o(c_o), .c_we_o(c_we_o),
    .n_o(n_o), .n_we_o(n_we_o), .v_o(v_o), .v_we_o(v_we_o), .t_o(t_o), .t_we_o(t_we_o)
  );

  typedef struct packed {
    logic [7:0] res;
    logic res_we, z, zwe, c, cwe, n, nwe, v, vwe, t, twe;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  function automatic exp_t model(int op, int a, int b, int ci, int ti, bit vld);
    exp_t e = '0;
    int r = 0, co = 0, m;
    if (!vld) return e;
    if (op <= 4) begin
      case (op)
        0: begin r = (a * 2) % 256;           co = a / 128; end
        1: begin r = a / 2;                   co = a % 2;   end
        2: begin r = (a * 2) % 256 + ci;      co = a / 128; end
        3: begin r = a / 2 + ci * 128;        co = a % 2;   end
        default: begin r = a / 2 + (a / 128) * 128; co = a % 2; end
      endcase
      e.res = 8'(r); e.res_we = 1'b1;
      e.c = (co != 0); e.n = (r >= 128); e.z = (r == 0); e.v = e.n ^ e.c;
      e.zwe = 1'b1; e.cwe = 1'b1; e.nwe = 1'b1; e.vwe = 1'b1;
    end else if (op == 5) begin
      e.res = 8'((a % 16) * 16 + a / 16); e.res_we = 1'b1;
    end else if (op == 6) begin
      e.t = (((a >> b) & 1) != 0); e.twe = 1'b1;
    end else begin
      m = 1 << b;
      e.res = 8'((ti != 0) ? (a | m) : (a & (255 - m))); e.res_we = 1'b1;
    end
    return e;
  endfunction

  function automatic string tag_of(int op, bit vld);
    if (!vld) return "R11 R10";
    case (op)
      0: return "R1 R6 R10";
      1: return "R2 R6 R10";
      2: return "R3 R6 R10";
      3: return "R4 R6 R10";
      4: return "R5 R6 R10";
      5: return "R7 R10";
      6: return "R8 R10";
      default: return "R9 R10";
    endcase
  endfunction

  function automatic exp_t observed();
    exp_t g;
    g = {result_o, result_we_o, z_o, z_we_o, c_o, c_we_o, n_o, n_we_o, v_o, v_we_o, t_o, t_we_o};
    return g;
  endfunction

  task automatic compare(exp_t e, string tag);
    exp_t g = observed();
    n_cmp++;
    if (g !== e) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, g, e);
    end
  endtask

  // One cycle: check the previous operation, then issue the next one
  task automatic step(int op, int a, int b, int ci, int ti, bit vld);
    @(negedge clk);
    if (expq.size() > 0) compare(expq.pop_front(), tagq.pop_front());
    valid_i = vld; op_i = 3'(op); operand_i = 8'(a); bit_sel_i = 3'(b);
    c_i = ci[0]; t_i = ti[0];
    expq.push_back(model(op, a, b, ci, ti, vld));
    tagq.push_back(tag_of(op, vld));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    int corners[7] = '{8'h00, 8'h80, 8'h01, 8'hFF, 8'h7F, 8'h55, 8'hAA};
    // R12: outputs stay zero in reset even with an operation presented
    valid_i = 1'b1; op_i = 3'd2; operand_i = 8'hFF; c_i = 1'b1; t_i = 1'b1;
    repeat (3) @(negedge clk);
    compare('0, "R12");
    rst_n = 1'b1;
    valid_i = 1'b0;
    expq.push_back('0); tagq.push_back("R11 R12");

    // Directed corners for every operation and carry value
    for (int op = 0; op < 8; op++)
      for (int k = 0; k < 7; k++)
        for (int ci = 0; ci < 2; ci++)
          step(op, corners[k], (k + ci) % 8, ci, 1 - ci, 1'b1);

    // Every bit index for bit store and bit load, both T values
    for (int b = 0; b < 8; b++)
      for (int ti = 0; ti < 2; ti++) begin
        step(6, 8'hA5, b, ti, ti, 1'b1);
        step(7, 8'hA5, b, 0, ti, 1'b1);
        step(7, 8'h5A, b, 1, ti, 1'b0);
      end

    // Idle cycles between operations
    step(0, 8'hFF, 0, 1, 1, 1'b0);
    step(3, 8'h01, 0, 1, 0, 1'b1);
    step(3, 8'h01, 0, 1, 0, 1'b0);
    step(5, 8'h3C, 0, 0, 0, 1'b1);

    // Mixed traffic
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 7), $urandom_range(0, 255), $urandom_range(0, 7),
           $urandom_range(0, 1), $urandom_range(0, 1), ($urandom_range(0, 7) != 0));

    step(0, 0, 0, 0, 0, 1'b0);
    step(0, 0, 0, 0, 0, 1'b0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R10: watchdog expired, got hang expected completion");
      summary();
      $finish;
    end
  end

endmodule